// File: doc/BRIEF.md
# Two-Input Threshold Neuron

This block is one neuron cell of a small pixel-grid pattern detector. A start pulse loads two unsigned sub-inputs and the weight for each. Two sequential shift-and-add multipliers form the two products in parallel, retiring one multiplier bit per clock, least significant bit first. The two products are added, and a hard threshold decides whether the neuron fires.

The decision is a single `active` bit. The raw weighted sum is also brought out for debug. A `done` strobe marks the cycle in which both outputs are refreshed. Both outputs then hold their values until the next completion. The threshold is a fixed parameter. By default it is half of the largest reachable sum. A start that arrives while an evaluation is in flight is dropped.

Top module: `threshold_neuron`

## Requirements
- R1: While reset is high and after it is released, and before any completion, `done`, `active` and `sum` are all 0.
- R2: At completion, `sum` equals x_a*w_a + x_b*w_b. All four operands are unsigned 4-bit values.
- R3: At completion, `active` is 1 exactly when `sum` is strictly greater than THRESH. The default THRESH is 225, so a sum of 225 gives 0 and a sum of 226 gives 1.
- R4: When `start` is sampled high at a clock edge while the neuron is idle, `done` goes high for exactly one cycle, right after the fifth clock edge that follows.
- R5: A `start` sampled at any of those five following edges is ignored. It produces no extra `done` pulse and does not alter the result.
- R6: `sum` and `active` change only at a completion and hold their values between completions.
- R7: The operands are captured at the accepting edge. Later changes on the operand inputs do not affect that evaluation.
- R8: The largest operands (all four equal to 15) give a sum of 450 without wrap-around, and `active` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to evaluate the current operands |
| x_a | input | 4 | First sub-input |
| w_a | input | 4 | Weight of the first sub-input |
| x_b | input | 4 | Second sub-input |
| w_b | input | 4 | Weight of the second sub-input |
| done | output | 1 | One-cycle completion strobe |
| active | output | 1 | Neuron fires: sum above threshold |
| sum | output | 9 | Raw weighted sum of the last evaluation |

## Verification
The timing assertion models acceptance only from the `start` pin. It assumes `start` is a plain synchronous level that can stay high or toggle during a run, and that reset is the only other thing that aborts an evaluation. The stimulus always drives `start` and the operands on the falling edge. It deliberately raises `start` with fresh operands during each busy window of the overlap tests, so the drop rule is exercised without breaking those assumptions. Reset is applied only before any operation is issued.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    function automatic int unsigned max_sum(input int unsigned data_w);
        int unsigned top;
        top = (1 << data_w) - 1;
        return 2 * top * top;
    endfunction

endpackage

// File: rtl/neuron_seq.sv
module neuron_seq
    import neuron_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic finish,
    output logic done_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] bit_idx;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        finish   = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    load        = 1'b1;
                    r_d.state   = SEQ_RUN;
                    r_d.bit_idx = '0;
                end
            end
            SEQ_RUN: begin
                step = 1'b1;
                if (r_q.bit_idx == LAST_BIT) begin
                    r_d.state = SEQ_FIN;
                end else begin
                    r_d.bit_idx = r_q.bit_idx + 1'b1;
                end
            end
            SEQ_FIN: begin
                finish    = 1'b1;
                r_d.done  = 1'b1;
                r_d.state = SEQ_IDLE;
            end
            default: begin
                r_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state   <= SEQ_IDLE;
            r_q.bit_idx <= '0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int DATA_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  step,
    input  logic [DATA_W-1:0]     mcand_in,
    input  logic [DATA_W-1:0]     mplier_in,
    output logic [2*DATA_W-1:0]   prod_o
);
    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [PROD_W-1:0] mcand;
        logic [DATA_W-1:0] mplier;
        logic [PROD_W-1:0] acc;
    } mul_regs_t;

    mul_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.mcand  = {{DATA_W{1'b0}}, mcand_in};
            r_d.mplier = mplier_in;
            r_d.acc    = '0;
        end else if (step) begin
            if (r_q.mplier[0]) begin
                r_d.acc = r_q.acc + r_q.mcand;
            end
            r_d.mcand  = r_q.mcand << 1;
            r_d.mplier = r_q.mplier >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prod_o = r_q.acc;

endmodule

// File: rtl/neuron_act.sv
module neuron_act #(
    parameter int DATA_W = 4,
    parameter int THRESH = 225
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  logic [2*DATA_W-1:0]   prod_a,
    input  logic [2*DATA_W-1:0]   prod_b,
    output logic [2*DATA_W:0]     sum_o,
    output logic                  active_o
);
    localparam int SUM_W = 2 * DATA_W + 1;
    localparam logic [SUM_W-1:0] THR_V = SUM_W'(THRESH);

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic             active;
    } act_regs_t;

    act_regs_t r_q, r_d;
    logic [SUM_W-1:0] total;

    always_comb begin
        total = {1'b0, prod_a} + {1'b0, prod_b};
        r_d   = r_q;
        if (capture) begin
            r_d.sum    = total;
            r_d.active = (total > THR_V);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sum_o    = r_q.sum;
    assign active_o = r_q.active;

endmodule

// File: rtl/threshold_neuron.sv
module threshold_neuron #(
    parameter int DATA_W = 4,
    parameter int THRESH = ((1 << DATA_W) - 1) * ((1 << DATA_W) - 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DATA_W-1:0]   x_a,
    input  logic [DATA_W-1:0]   w_a,
    input  logic [DATA_W-1:0]   x_b,
    input  logic [DATA_W-1:0]   w_b,
    output logic                done,
    output logic                active,
    output logic [2*DATA_W:0]   sum
);
    localparam int N_LANE = 2;
    localparam int PROD_W = 2 * DATA_W;

    logic load, step, finish;
    logic [DATA_W-1:0] lane_x [N_LANE];
    logic [DATA_W-1:0] lane_w [N_LANE];
    logic [PROD_W-1:0] lane_p [N_LANE];

    assign lane_x[0] = x_a;
    assign lane_w[0] = w_a;
    assign lane_x[1] = x_b;
    assign lane_w[1] = w_b;

    neuron_seq #(.DATA_W(DATA_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load   (load),
        .step   (step),
        .finish (finish),
        .done_o (done)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        shift_add_mul #(.DATA_W(DATA_W)) u_mul (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .step      (step),
            .mcand_in  (lane_x[g]),
            .mplier_in (lane_w[g]),
            .prod_o    (lane_p[g])
        );
    end

    neuron_act #(.DATA_W(DATA_W), .THRESH(THRESH)) u_act (
        .clk      (clk),
        .rst      (rst),
        .capture  (finish),
        .prod_a   (lane_p[0]),
        .prod_b   (lane_p[1]),
        .sum_o    (sum),
        .active_o (active)
    );

endmodule

// File: rtl/neuron_chk.sv
module neuron_chk #(
    parameter int DATA_W = 4,
    parameter int THRESH = 225
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              active,
    input logic [2*DATA_W:0] sum
);
    localparam int SUM_W = 2 * DATA_W + 1;
    localparam logic [SUM_W-1:0] THR_V = SUM_W'(THRESH);
    localparam logic [SUM_W-1:0] MAX_V = SUM_W'(neuron_pkg::max_sum(DATA_W));
    localparam int WIN = DATA_W + 1;

    logic [7:0] win_q;
    logic       exp_done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q      <= '0;
            exp_done_q <= 1'b0;
        end else begin
            exp_done_q <= (win_q == 8'(WIN));
            if (win_q == 8'd0) begin
                if (start) win_q <= 8'd1;
            end else if (win_q == 8'(WIN)) begin
                win_q <= 8'd0;
            end else begin
                win_q <= win_q + 8'd1;
            end
        end
    end

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
        done == exp_done_q); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_FIRE_RULE: assert property (@(posedge clk) disable iff (rst)
        done |-> (active == (sum > THR_V))); // R3
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(sum) && $stable(active))); // R6
    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst)
        sum <= MAX_V); // R8

endmodule

bind threshold_neuron neuron_chk #(.DATA_W(DATA_W), .THRESH(THRESH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .active (active),
    .sum    (sum)
);

// File: tb/threshold_neuron_test.sv
module threshold_neuron_test;
    localparam int CLK_PERIOD = 10;
    localparam int THR = 225;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] x_a = '0, w_a = '0, x_b = '0, w_b = '0;
    logic       done, active;
    logic [8:0] sum;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    threshold_neuron uut (
        .clk(clk), .rst(rst), .start(start),
        .x_a(x_a), .w_a(w_a), .x_b(x_b), .w_b(w_b),
        .done(done), .active(active), .sum(sum)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // poke: raise start with other operands during every busy cycle (R5, R7)
    task automatic run_op(input logic [3:0] xa, input logic [3:0] wa,
                          input logic [3:0] xb, input logic [3:0] wb,
                          input bit poke);
        int exp_sum;
        bit exp_act;
        logic [8:0] prev_sum;
        logic       prev_act;
        exp_sum = int'(xa) * int'(wa) + int'(xb) * int'(wb);
        exp_act = exp_sum > THR;
        prev_sum = sum;
        prev_act = active;
        x_a = xa; w_a = wa; x_b = xb; w_b = wb;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = poke;
        if (poke) begin
            x_a = ~xa; w_a = ~wa; x_b = ~xb; w_b = ~wb;
        end
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(done == 1'b0, "R4 early done", int'(done), 0);
            check(sum == prev_sum && active == prev_act, "R6 hold during run",
                  int'(sum), int'(prev_sum));
            if (poke) begin
                x_a = 4'(k * 3); w_a = 4'(k * 5); x_b = 4'(k + 9); w_b = 4'(k * 7);
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R4 done at fifth edge", int'(done), 1);
        check(int'(sum) == exp_sum, poke ? "R7 sum with changed operands" : "R2 sum",
              int'(sum), exp_sum);
        check(active == exp_act, "R3 threshold", int'(active), int'(exp_act));
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R4 single-cycle done", int'(done), 0);
        check(int'(sum) == exp_sum, "R6 hold after done", int'(sum), exp_sum);
        if (poke) begin
            for (int k = 0; k < 6; k++) begin
                @(posedge clk);
                @(negedge clk);
                check(done == 1'b0, "R5 busy start ignored", int'(done), 0);
                check(int'(sum) == exp_sum, "R5 result kept", int'(sum), exp_sum);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(done == 1'b0 && active == 1'b0 && sum == '0, "R1 reset state",
                  int'(sum), 0);
        end
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(done == 1'b0 && active == 1'b0 && sum == '0, "R1 idle after reset",
                  int'(sum), 0);
        end

        // R3 boundary: 225 does not fire, 226 does
        run_op(4'd15, 4'd15, 4'd0, 4'd9, 1'b0);
        run_op(4'd15, 4'd15, 4'd1, 4'd1, 1'b0);
        run_op(4'd0, 4'd7, 4'd15, 4'd15, 1'b0);
        // R8 maximum
        run_op(4'd15, 4'd15, 4'd15, 4'd15, 1'b0);
        run_op(4'd0, 4'd0, 4'd0, 4'd0, 1'b0);
        // R5 / R7 overlapping starts with changing operands
        run_op(4'd9, 4'd13, 4'd6, 4'd11, 1'b1);
        run_op(4'd15, 4'd15, 4'd15, 4'd14, 1'b1);
        run_op(4'd1, 4'd2, 4'd3, 4'd4, 1'b1);

        // R2/R3 near-exhaustive sweep: every first lane pair, 16 second lane pairs
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                run_op(4'(a >> 4), 4'(a), 4'(k), 4'((k * 7 + a) % 16), 1'b0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule